// File: doc/BRIEF.md
# DMA Frame and Element Address Generator

This block generates the read and write addresses for one DMA channel. A control packet loaded through the configuration port gives the initial source and destination addresses and the number of elements per frame. It also gives the number of frames per block, the element and frame offsets for each side, an addressing mode for each side, the read and write element sizes, and an auto-initiation flag. After a trigger, the block offers one source/destination address pair per element. It advances only when the downstream transfer engine accepts the pair. It pulses a flag at the end of each frame and at the end of the block.

The primary configuration is held apart from the working state: the current source address, the current destination address and the element and frame counters. A block can therefore be rerun from the unchanged settings. With auto-initiation on, the working state reloads itself at the end of a block and the channel carries on. With auto-initiation off, the channel stops and stays stopped until it is configured again. A trigger is refused with an error pulse in two cases: a start address is not aligned to its element size, or a count is zero.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `xfer_valid`, `busy`, `frame_done`, `block_done` and `cfg_err` are all 0.
- R2: A `cfg_load` pulse captures the packet and sets the working state from it. In the next cycle `cur_elem_cnt` and `cur_frame_cnt` equal the loaded counts and `busy` is 0, even if a block was running.
- R3: A `start` pulse while idle, with a valid packet, raises `xfer_valid` in the next cycle. The first pair is the initial source and destination address, and `xfer_rd_size`/`xfer_wr_size` carry the configured sizes (code 0..3 = 8, 16, 32, 64 bits).
- R4: In indexed mode (code 2), each accepted element that is not the last of its frame moves the address by the signed element offset. The last element of a frame moves it by the signed frame offset instead.
- R5: In post-increment mode (code 1), each accepted element moves the address by the element size in bytes (1, 2, 4 or 8).
- R6: In fixed mode (code 0), and for code 3, the address never moves and the offsets are ignored.
- R7: The addresses change only when an element is accepted (`xfer_valid` and `xfer_ready` both high). A pair that is not accepted is held.
- R8: `frame_done` pulses in the cycle after the last element of each frame is accepted. A block is exactly element count times frame count elements.
- R9: `block_done` pulses together with the final `frame_done`. With auto-initiation off, `busy` is then 0 and any further `start` is ignored until the next `cfg_load`.
- R10: With auto-initiation on, the end of a block reloads the working state from the primary configuration. The next pair is the initial pair, offered without a new `start`.
- R11: A `start` fails in three cases: the source address is misaligned to the read size, the destination address is misaligned to the write size, or a count is zero. In each case `cfg_err` pulses for one cycle and no pair is offered.
- R12: A `start` while `busy` is 1 has no effect on the address sequence or the element count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture the packet and reset the working state |
| cfg_src_addr | input | ADDR_W | Initial source address |
| cfg_dst_addr | input | ADDR_W | Initial destination address |
| cfg_elem_cnt | input | CNT_W | Elements per frame |
| cfg_frame_cnt | input | CNT_W | Frames per block |
| cfg_src_elem_off | input | OFF_W | Signed source element offset |
| cfg_src_frame_off | input | OFF_W | Signed source frame offset |
| cfg_dst_elem_off | input | OFF_W | Signed destination element offset |
| cfg_dst_frame_off | input | OFF_W | Signed destination frame offset |
| cfg_src_mode | input | 2 | Source addressing mode |
| cfg_dst_mode | input | 2 | Destination addressing mode |
| cfg_rd_size | input | 2 | Read element size code |
| cfg_wr_size | input | 2 | Write element size code |
| cfg_auto_init | input | 1 | Reload and rerun at the end of a block |
| start | input | 1 | Trigger pulse |
| xfer_ready | input | 1 | Transfer engine accepts the offered pair |
| xfer_valid | output | 1 | A pair is offered |
| xfer_src_addr | output | ADDR_W | Current read address |
| xfer_dst_addr | output | ADDR_W | Current write address |
| xfer_rd_size | output | 2 | Read size code |
| xfer_wr_size | output | 2 | Write size code |
| frame_done | output | 1 | End-of-frame pulse |
| block_done | output | 1 | End-of-block pulse |
| cfg_err | output | 1 | Refused-trigger pulse |
| busy | output | 1 | Block in progress |
| cur_elem_cnt | output | CNT_W | Elements left in the current frame |
| cur_frame_cnt | output | CNT_W | Frames left in the block |

## Verification
A wrong address step shows on `xfer_src_addr` or `xfer_dst_addr` in the cycle right after the faulty element is accepted. The bench compares every pair against an address computed from the frame and element index, so a wrong offset, a wrong size or a wrong mode is caught on the first element where it matters. A corrupted element or frame counter shows within one frame: `frame_done` or `block_done` appears one cycle early or late, or `busy` fails to drop. A stale reload after the block ends shows in the cycle after `block_done` as a non-initial pair.

// File: rtl/dma_agu_pkg.sv
package dma_agu_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } elem_size_e;

    typedef enum logic [1:0] {
        AM_FIXED   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_INDEXED = 2'd2,
        AM_HOLD    = 2'd3
    } addr_mode_e;

    localparam int unsigned ALIGN_LSBS = 3;

endpackage

// File: rtl/dma_agu_prim.sv
module dma_agu_prim #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic [CNT_W-1:0]  elem_cnt_i,
    input  logic [CNT_W-1:0]  frame_cnt_i,
    input  logic [OFF_W-1:0]  src_eoff_i,
    input  logic [OFF_W-1:0]  src_foff_i,
    input  logic [OFF_W-1:0]  dst_eoff_i,
    input  logic [OFF_W-1:0]  dst_foff_i,
    input  logic [1:0]        src_mode_i,
    input  logic [1:0]        dst_mode_i,
    input  logic [1:0]        rd_size_i,
    input  logic [1:0]        wr_size_i,
    input  logic              auto_i,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic [CNT_W-1:0]  elem_cnt_o,
    output logic [CNT_W-1:0]  frame_cnt_o,
    output logic [OFF_W-1:0]  src_eoff_o,
    output logic [OFF_W-1:0]  src_foff_o,
    output logic [OFF_W-1:0]  dst_eoff_o,
    output logic [OFF_W-1:0]  dst_foff_o,
    output logic [1:0]        src_mode_o,
    output logic [1:0]        dst_mode_o,
    output logic [1:0]        rd_size_o,
    output logic [1:0]        wr_size_o,
    output logic              auto_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  elem;
        logic [CNT_W-1:0]  frame;
        logic [OFF_W-1:0]  seo;
        logic [OFF_W-1:0]  sfo;
        logic [OFF_W-1:0]  deo;
        logic [OFF_W-1:0]  dfo;
        logic [1:0]        smode;
        logic [1:0]        dmode;
        logic [1:0]        rsz;
        logic [1:0]        wsz;
        logic              auto_en;
    } prim_t;

    prim_t prim_d, prim_q;

    // Primary settings change only on an explicit load; transfers never write them.
    always_comb begin
        prim_d = prim_q;
        if (load_i) begin
            prim_d.src     = src_addr_i;
            prim_d.dst     = dst_addr_i;
            prim_d.elem    = elem_cnt_i;
            prim_d.frame   = frame_cnt_i;
            prim_d.seo     = src_eoff_i;
            prim_d.sfo     = src_foff_i;
            prim_d.deo     = dst_eoff_i;
            prim_d.dfo     = dst_foff_i;
            prim_d.smode   = src_mode_i;
            prim_d.dmode   = dst_mode_i;
            prim_d.rsz     = rd_size_i;
            prim_d.wsz     = wr_size_i;
            prim_d.auto_en = auto_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prim_q <= '0;
        else        prim_q <= prim_d;
    end

    assign src_addr_o  = prim_q.src;
    assign dst_addr_o  = prim_q.dst;
    assign elem_cnt_o  = prim_q.elem;
    assign frame_cnt_o = prim_q.frame;
    assign src_eoff_o  = prim_q.seo;
    assign src_foff_o  = prim_q.sfo;
    assign dst_eoff_o  = prim_q.deo;
    assign dst_foff_o  = prim_q.dfo;
    assign src_mode_o  = prim_q.smode;
    assign dst_mode_o  = prim_q.dmode;
    assign rd_size_o   = prim_q.rsz;
    assign wr_size_o   = prim_q.wsz;
    assign auto_o      = prim_q.auto_en;

endmodule

// File: rtl/dma_agu_step.sv
module dma_agu_step
    import dma_agu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [OFF_W-1:0]  elem_off_i,
    input  logic [OFF_W-1:0]  frame_off_i,
    input  logic              frame_end_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int unsigned EXT_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0]  off_sel;
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] size_inc;

    always_comb begin
        off_sel  = frame_end_i ? frame_off_i : elem_off_i;
        off_ext  = {{EXT_W{off_sel[OFF_W-1]}}, off_sel};
        size_inc = ADDR_W'(1) << size_i;
        case (addr_mode_e'(mode_i))
            AM_POSTINC: addr_o = addr_i + size_inc;
            AM_INDEXED: addr_o = addr_i + off_ext;
            default:    addr_o = addr_i;
        endcase
    end

endmodule

// File: rtl/dma_agu_align.sv
module dma_agu_align
    import dma_agu_pkg::*;
(
    input  logic [ALIGN_LSBS-1:0] addr_lo_i,
    input  logic [1:0]            size_i,
    output logic                  misalign_o
);

    logic [ALIGN_LSBS-1:0] mask;

    // Mask of low address bits that must be zero for the element size.
    always_comb begin
        for (int b = 0; b < ALIGN_LSBS; b++) begin
            mask[b] = (b < int'(size_i));
        end
        misalign_o = |(addr_lo_i & mask);
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_agu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_elem_cnt,
    input  logic [CNT_W-1:0]  cfg_frame_cnt,
    input  logic [OFF_W-1:0]  cfg_src_elem_off,
    input  logic [OFF_W-1:0]  cfg_src_frame_off,
    input  logic [OFF_W-1:0]  cfg_dst_elem_off,
    input  logic [OFF_W-1:0]  cfg_dst_frame_off,
    input  logic [1:0]        cfg_src_mode,
    input  logic [1:0]        cfg_dst_mode,
    input  logic [1:0]        cfg_rd_size,
    input  logic [1:0]        cfg_wr_size,
    input  logic              cfg_auto_init,
    input  logic              start,
    input  logic              xfer_ready,
    output logic              xfer_valid,
    output logic [ADDR_W-1:0] xfer_src_addr,
    output logic [ADDR_W-1:0] xfer_dst_addr,
    output logic [1:0]        xfer_rd_size,
    output logic [1:0]        xfer_wr_size,
    output logic              frame_done,
    output logic              block_done,
    output logic              cfg_err,
    output logic              busy,
    output logic [CNT_W-1:0]  cur_elem_cnt,
    output logic [CNT_W-1:0]  cur_frame_cnt
);

    localparam int unsigned NSIDE = 2;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  elem;
        logic [CNT_W-1:0]  frame;
        logic              fdone;
        logic              bdone;
        logic              err;
    } work_t;

    work_t st_d, st_q;

    // Primary configuration
    logic [ADDR_W-1:0] p_src, p_dst;
    logic [CNT_W-1:0]  p_elem, p_frame;
    logic [OFF_W-1:0]  p_seo, p_sfo, p_deo, p_dfo;
    logic [1:0]        p_smode, p_dmode, p_rsz, p_wsz;
    logic              p_auto;

    dma_agu_prim #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_prim (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cfg_load),
        .src_addr_i  (cfg_src_addr),
        .dst_addr_i  (cfg_dst_addr),
        .elem_cnt_i  (cfg_elem_cnt),
        .frame_cnt_i (cfg_frame_cnt),
        .src_eoff_i  (cfg_src_elem_off),
        .src_foff_i  (cfg_src_frame_off),
        .dst_eoff_i  (cfg_dst_elem_off),
        .dst_foff_i  (cfg_dst_frame_off),
        .src_mode_i  (cfg_src_mode),
        .dst_mode_i  (cfg_dst_mode),
        .rd_size_i   (cfg_rd_size),
        .wr_size_i   (cfg_wr_size),
        .auto_i      (cfg_auto_init),
        .src_addr_o  (p_src),
        .dst_addr_o  (p_dst),
        .elem_cnt_o  (p_elem),
        .frame_cnt_o (p_frame),
        .src_eoff_o  (p_seo),
        .src_foff_o  (p_sfo),
        .dst_eoff_o  (p_deo),
        .dst_foff_o  (p_dfo),
        .src_mode_o  (p_smode),
        .dst_mode_o  (p_dmode),
        .rd_size_o   (p_rsz),
        .wr_size_o   (p_wsz),
        .auto_o      (p_auto)
    );

    // Per-side address step and alignment check; side 0 reads, side 1 writes.
    logic [ADDR_W-1:0] side_cur  [NSIDE];
    logic [ADDR_W-1:0] side_nxt  [NSIDE];
    logic [1:0]        side_mode [NSIDE];
    logic [1:0]        side_size [NSIDE];
    logic [OFF_W-1:0]  side_eoff [NSIDE];
    logic [OFF_W-1:0]  side_foff [NSIDE];
    logic              side_mis  [NSIDE];
    logic              last_elem, last_frame;

    assign side_cur[0]  = st_q.src;
    assign side_cur[1]  = st_q.dst;
    assign side_mode[0] = p_smode;
    assign side_mode[1] = p_dmode;
    assign side_size[0] = p_rsz;
    assign side_size[1] = p_wsz;
    assign side_eoff[0] = p_seo;
    assign side_eoff[1] = p_deo;
    assign side_foff[0] = p_sfo;
    assign side_foff[1] = p_dfo;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_agu_step #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_step (
            .addr_i      (side_cur[s]),
            .mode_i      (side_mode[s]),
            .size_i      (side_size[s]),
            .elem_off_i  (side_eoff[s]),
            .frame_off_i (side_foff[s]),
            .frame_end_i (last_elem),
            .addr_o      (side_nxt[s])
        );
        dma_agu_align u_align (
            .addr_lo_i  (side_cur[s][ALIGN_LSBS-1:0]),
            .size_i     (side_size[s]),
            .misalign_o (side_mis[s])
        );
    end

    logic accept, bad_start;

    always_comb begin
        last_elem  = (st_q.elem == CNT_ONE);
        last_frame = (st_q.frame == CNT_ONE);
        accept     = st_q.busy & xfer_ready;
        bad_start  = side_mis[0] | side_mis[1] | (p_elem == '0) | (p_frame == '0);

        st_d       = st_q;
        st_d.fdone = 1'b0;
        st_d.bdone = 1'b0;
        st_d.err   = 1'b0;

        if (cfg_load) begin
            st_d.busy  = 1'b0;
            st_d.done  = 1'b0;
            st_d.src   = cfg_src_addr;
            st_d.dst   = cfg_dst_addr;
            st_d.elem  = cfg_elem_cnt;
            st_d.frame = cfg_frame_cnt;
        end else if (accept) begin
            st_d.src = side_nxt[0];
            st_d.dst = side_nxt[1];
            if (last_elem) begin
                st_d.fdone = 1'b1;
                if (last_frame) begin
                    st_d.bdone = 1'b1;
                    if (p_auto) begin
                        st_d.src   = p_src;
                        st_d.dst   = p_dst;
                        st_d.elem  = p_elem;
                        st_d.frame = p_frame;
                    end else begin
                        st_d.busy  = 1'b0;
                        st_d.done  = 1'b1;
                        st_d.elem  = '0;
                        st_d.frame = '0;
                    end
                end else begin
                    st_d.frame = st_q.frame - CNT_ONE;
                    st_d.elem  = p_elem;
                end
            end else begin
                st_d.elem = st_q.elem - CNT_ONE;
            end
        end else if (start && !st_q.busy && !st_q.done) begin
            if (bad_start) st_d.err  = 1'b1;
            else           st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xfer_valid    = st_q.busy;
    assign xfer_src_addr = st_q.src;
    assign xfer_dst_addr = st_q.dst;
    assign xfer_rd_size  = p_rsz;
    assign xfer_wr_size  = p_wsz;
    assign frame_done    = st_q.fdone;
    assign block_done    = st_q.bdone;
    assign cfg_err       = st_q.err;
    assign busy          = st_q.busy;
    assign cur_elem_cnt  = st_q.elem;
    assign cur_frame_cnt = st_q.frame;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic src_is_fixed;
    assign src_is_fixed = (p_smode == AM_FIXED) || (p_smode == AM_HOLD);

    p_hold_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready && !cfg_load) |=> ($stable(xfer_src_addr) && $stable(xfer_dst_addr)));

    p_fixed_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && src_is_fixed && !cfg_load) |=> $stable(xfer_src_addr));

    p_err_no_xfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !xfer_valid);

    p_block_has_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> frame_done);

    p_stop_no_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (block_done && !p_auto) |-> !busy);

    p_counts_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (cur_elem_cnt != '0 && cur_frame_cnt != '0));

endmodule

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;

    localparam int AW = 32;
    localparam int CW = 8;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [CW-1:0] cfg_elem_cnt = '0, cfg_frame_cnt = '0;
    logic [OW-1:0] cfg_src_elem_off = '0, cfg_src_frame_off = '0;
    logic [OW-1:0] cfg_dst_elem_off = '0, cfg_dst_frame_off = '0;
    logic [1:0]    cfg_src_mode = '0, cfg_dst_mode = '0, cfg_rd_size = '0, cfg_wr_size = '0;
    logic          cfg_auto_init = 1'b0;
    logic          start = 1'b0;
    logic          xfer_ready = 1'b1;

    logic          xfer_valid, frame_done, block_done, cfg_err, busy;
    logic [AW-1:0] xfer_src_addr, xfer_dst_addr;
    logic [1:0]    xfer_rd_size, xfer_wr_size;
    logic [CW-1:0] cur_elem_cnt, cur_frame_cnt;

    always #10 clk = ~clk;

    dma_addr_gen #(.ADDR_W(AW), .CNT_W(CW), .OFF_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_elem_cnt(cfg_elem_cnt), .cfg_frame_cnt(cfg_frame_cnt),
        .cfg_src_elem_off(cfg_src_elem_off), .cfg_src_frame_off(cfg_src_frame_off),
        .cfg_dst_elem_off(cfg_dst_elem_off), .cfg_dst_frame_off(cfg_dst_frame_off),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_rd_size(cfg_rd_size), .cfg_wr_size(cfg_wr_size),
        .cfg_auto_init(cfg_auto_init), .start(start), .xfer_ready(xfer_ready),
        .xfer_valid(xfer_valid), .xfer_src_addr(xfer_src_addr), .xfer_dst_addr(xfer_dst_addr),
        .xfer_rd_size(xfer_rd_size), .xfer_wr_size(xfer_wr_size),
        .frame_done(frame_done), .block_done(block_done), .cfg_err(cfg_err),
        .busy(busy), .cur_elem_cnt(cur_elem_cnt), .cur_frame_cnt(cur_frame_cnt)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Model copy of the loaded packet
    logic [AW-1:0] g_src, g_dst;
    int g_E, g_F, g_seo, g_sfo, g_deo, g_dfo, g_sm, g_dm, g_rs, g_ws;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] model(input logic [AW-1:0] init, input int mode, input int sz,
                                            input int eo, input int fo, input int n);
        int per = g_E * g_F;
        int k = n % per;
        int f = k / g_E;
        int e = k % g_E;
        case (mode)
            1:       return init + AW'(k * (1 << sz));
            2:       return init + AW'(f * (fo + (g_E - 1) * eo) + e * eo);
            default: return init;
        endcase
    endfunction

    task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d, input int e, input int f,
                        input int seo, input int sfo, input int deo, input int dfo,
                        input int sm, input int dm, input int rs, input int ws, input bit au);
        @(negedge clk);
        g_src = s; g_dst = d; g_E = e; g_F = f;
        g_seo = seo; g_sfo = sfo; g_deo = deo; g_dfo = dfo;
        g_sm = sm; g_dm = dm; g_rs = rs; g_ws = ws;
        cfg_src_addr = s; cfg_dst_addr = d;
        cfg_elem_cnt = CW'(e); cfg_frame_cnt = CW'(f);
        cfg_src_elem_off = OW'(seo); cfg_src_frame_off = OW'(sfo);
        cfg_dst_elem_off = OW'(deo); cfg_dst_frame_off = OW'(dfo);
        cfg_src_mode = 2'(sm); cfg_dst_mode = 2'(dm);
        cfg_rd_size = 2'(rs); cfg_wr_size = 2'(ws);
        cfg_auto_init = au;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Starts at a negedge, follows 'total' accepted elements with ready held high.
    task automatic run_stream(input string req, input int total);
        int per = g_E * g_F;
        int k;
        xfer_ready = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < total; n++) begin
            if (n > 0) begin
                k = (n - 1) % per;
                chk(req, "frame_done", 64'(frame_done), 64'(k % g_E == g_E - 1));
                chk(req, "block_done", 64'(block_done), 64'(k == per - 1));
            end
            chk(req, "xfer_valid", 64'(xfer_valid), 64'd1);
            chk(req, "src", 64'(xfer_src_addr), 64'(model(g_src, g_sm, g_rs, g_seo, g_sfo, n)));
            chk(req, "dst", 64'(xfer_dst_addr), 64'(model(g_dst, g_dm, g_ws, g_deo, g_dfo, n)));
            @(negedge clk);
        end
        k = (total - 1) % per;
        chk(req, "frame_done last", 64'(frame_done), 64'(k % g_E == g_E - 1));
        chk(req, "block_done last", 64'(block_done), 64'(k == per - 1));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "xfer_valid", 64'(xfer_valid), 64'd0);
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "frame_done", 64'(frame_done), 64'd0);
        chk("R1", "block_done", 64'(block_done), 64'd0);
        chk("R1", "cfg_err", 64'(cfg_err), 64'd0);
    endtask

    task automatic t_two_level;
        // R4 indexed source, R5 post-increment destination, R8 frames, R9 stop
        load(32'h1000, 32'h2000, 3, 2, 8, -12, 0, 0, 2, 1, 2, 1, 1'b0);
        chk("R2", "cur_elem_cnt", 64'(cur_elem_cnt), 64'd3);
        chk("R2", "cur_frame_cnt", 64'(cur_frame_cnt), 64'd2);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R3", "rd_size", 64'(xfer_rd_size), 64'd2);
        chk("R3", "wr_size", 64'(xfer_wr_size), 64'd1);
        chk("R3", "first src", 64'(xfer_src_addr), 64'h1000);
        load(32'h1000, 32'h2000, 3, 2, 8, -12, 0, 0, 2, 1, 2, 1, 1'b0);
        run_stream("R4", 6);
        chk("R9", "busy after block", 64'(busy), 64'd0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R9", "restart ignored", 64'(xfer_valid), 64'd0);
        chk("R9", "no error", 64'(cfg_err), 64'd0);
    endtask

    task automatic t_fixed;
        load(32'h3000, 32'h4008, 2, 2, 16, 32, 16, 32, 0, 3, 3, 3, 1'b0);
        run_stream("R6", 4);
    endtask

    task automatic t_postinc;
        load(32'h5001, 32'h6000, 4, 1, 0, 0, 0, 0, 1, 1, 0, 3, 1'b0);
        run_stream("R5", 4);
    endtask

    task automatic t_stall;
        load(32'h100, 32'h200, 2, 1, 4, 0, 16, 0, 2, 2, 2, 2, 1'b0);
        xfer_ready = 1'b0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R7", "valid while stalled", 64'(xfer_valid), 64'd1);
        chk("R7", "src held", 64'(xfer_src_addr), 64'h100);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R7", "src still held", 64'(xfer_src_addr), 64'h100);
        chk("R12", "dst held on busy start", 64'(xfer_dst_addr), 64'h200);
        xfer_ready = 1'b1;
        @(negedge clk);
        chk("R7", "src advanced", 64'(xfer_src_addr), 64'h104);
        chk("R7", "dst advanced", 64'(xfer_dst_addr), 64'h210);
        @(negedge clk);
        chk("R12", "block ends after 2", 64'(block_done), 64'd1);
        chk("R12", "busy dropped", 64'(busy), 64'd0);
        @(negedge clk);
        chk("R12", "no queued start", 64'(xfer_valid), 64'd0);
    endtask

    task automatic t_errors;
        // 32-bit read at 0x1002: misaligned
        load(32'h1002, 32'h2000, 1, 1, 0, 0, 0, 0, 1, 1, 2, 2, 1'b0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R11", "src misalign err", 64'(cfg_err), 64'd1);
        chk("R11", "src misalign no xfer", 64'(xfer_valid), 64'd0);
        @(negedge clk);
        chk("R11", "err one cycle", 64'(cfg_err), 64'd0);
        chk("R11", "still no xfer", 64'(xfer_valid), 64'd0);
        // 16-bit write at odd address
        load(32'h1000, 32'h2001, 1, 1, 0, 0, 0, 0, 1, 1, 2, 1, 1'b0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R11", "dst misalign err", 64'(cfg_err), 64'd1);
        chk("R11", "dst misalign no xfer", 64'(xfer_valid), 64'd0);
        // zero element count
        load(32'h1000, 32'h2000, 0, 1, 0, 0, 0, 0, 1, 1, 2, 2, 1'b0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk("R11", "zero count err", 64'(cfg_err), 64'd1);
        // 0x1002 is fine for 16-bit reads
        load(32'h1002, 32'h2000, 1, 1, 0, 0, 0, 0, 1, 1, 1, 2, 1'b0);
        run_stream("R11", 1);
        chk("R11", "aligned half no err", 64'(cfg_err), 64'd0);
    endtask

    task automatic t_autoinit;
        load(32'h800, 32'h900, 2, 2, 4, 32, 0, 0, 2, 1, 2, 2, 1'b1);
        run_stream("R10", 6);
        chk("R10", "still busy", 64'(busy), 64'd1);
        load(32'h40, 32'h80, 5, 7, 0, 0, 0, 0, 1, 1, 0, 0, 1'b0);
        chk("R2", "load aborts", 64'(xfer_valid), 64'd0);
        chk("R2", "busy cleared", 64'(busy), 64'd0);
        chk("R2", "elem count", 64'(cur_elem_cnt), 64'd5);
        chk("R2", "frame count", 64'(cur_frame_cnt), 64'd7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_two_level();
        t_fixed();
        t_postinc();
        t_stall();
        t_errors();
        t_autoinit();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule